// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block walks a DDR memory through its power-up command sequence once reset is released. It drives a memory controller through a simple request/acknowledge interface. Each step carries a 16-bit value on a data bus and either a one-hot memory command code or a one-hot configuration-write select. The step stays on the bus until the controller returns a single-cycle acknowledge. The sequencer then moves on to the next step.

Two strap pins are sampled once, in the first clock after reset is released. The first strap chooses between a first-generation DDR script (8 steps) and a DDR2 script (14 steps). The DDR2 script includes the calibration enter/exit pair and two auto-refresh commands. The second strap picks the refresh interval for a 40 MHz or a 25 MHz reference. Both scripts end with three configuration writes: the refresh control word, then the strobe delay tap for lane 0, then the tap for lane 1. After the last acknowledge the block raises `seq_done` and goes quiet.

The state machine has three states. SAMPLE is held during reset and lasts one cycle after release, while the straps are captured. On the next edge it always moves to ISSUE. ISSUE drives the current step. It stays in ISSUE until an acknowledge arrives. An acknowledge on a step that is not the last one increments the step index and stays in ISSUE. An acknowledge on the last step moves to DONE. DONE is terminal until reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `mem_cmd`, `cfg_sel` and `seq_done` are all zero.
- R2: At most one bit of the concatenation {`mem_cmd`, `cfg_sel`} is set in any cycle. `mem_cmd` bit 0 = load mode register, bit 1 = load extended mode register (EMR), bit 2 = auto-refresh, bit 3 = precharge-all, bit 4 = load EMR2, bit 5 = load EMR3. `cfg_sel` bit 0 = refresh control word, bit 1 = lane 0 tap, bit 2 = lane 1 tap. Commands that carry no value drive 0 on `wr_data`.
- R3: While a step is pending and `ctl_ack` is low, `mem_cmd`, `cfg_sel` and `wr_data` hold their values into the next cycle.
- R4: With the DDR2 strap high, the steps are: precharge-all; EMR2=0; EMR3=0; EMR=0; mode=0x100; precharge-all; auto-refresh; auto-refresh; mode=0xA33; EMR=0x382; EMR=0x402; then the three configuration writes.
- R5: With the DDR2 strap low, the steps are: precharge-all; mode=0x133; EMR=0x002; precharge-all; mode=0x033; then the three configuration writes.
- R6: The refresh control word has bit 14 set, the interval in bits 9:0 and all other bits zero. The interval is 624 with the 40 MHz strap high and 390 with it low.
- R7: The lane 0 tap write carries 0x08 and the lane 1 tap write carries 0x09, in that order, after the refresh word.
- R8: Strap values are taken only in the cycle after reset release. Later strap changes do not alter the script or the refresh word until the next reset.
- R9: `seq_done` rises in the cycle after the last step's acknowledge and stays high until reset. While it is high no request is driven and `ctl_ack` has no effect.
- R10: The sequencer advances only on `ctl_ack`. The next step appears in the cycle after the acknowledge, with no idle cycle between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ddr2 | input | 1 | 1 selects the DDR2 script, 0 the first-generation DDR script |
| strap_ref40 | input | 1 | 1 selects the 40 MHz refresh interval, 0 the 25 MHz interval |
| ctl_ack | input | 1 | One-cycle acknowledge of the pending step |
| mem_cmd | output | 6 | One-hot memory command of the pending step |
| cfg_sel | output | 3 | One-hot configuration-write select of the pending step |
| wr_data | output | DATA_W | Value carried by the pending step |
| seq_done | output | 1 | Sequence complete, sticky until reset |

## Verification
A wrong step index or a wrong latched strap shows up at the ports as soon as the next step is presented. One acknowledge later at most, `mem_cmd`, `cfg_sel` or `wr_data` differ from the expected script entry. If a transition to DONE is missed or taken early, the sequence length changes, and `seq_done` is wrong in the cycle after the final acknowledge. A state that ignores or double-counts an acknowledge appears as a stalled or skipped step within one cycle. The bench therefore compares every step of all four strap combinations under several acknowledge latencies. It also flips the straps in the middle of a run.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    localparam int CMD_W = 6;
    localparam int CFG_W = 3;

    // memory command one-hot codes
    localparam logic [CMD_W-1:0] CMD_NONE = 6'b000000;
    localparam logic [CMD_W-1:0] CMD_MRS  = 6'b000001;
    localparam logic [CMD_W-1:0] CMD_EMR  = 6'b000010;
    localparam logic [CMD_W-1:0] CMD_AREF = 6'b000100;
    localparam logic [CMD_W-1:0] CMD_PALL = 6'b001000;
    localparam logic [CMD_W-1:0] CMD_EMR2 = 6'b010000;
    localparam logic [CMD_W-1:0] CMD_EMR3 = 6'b100000;

    // configuration-write one-hot selects
    localparam logic [CFG_W-1:0] CFG_NONE = 3'b000;
    localparam logic [CFG_W-1:0] CFG_RFSH = 3'b001;
    localparam logic [CFG_W-1:0] CFG_TAP0 = 3'b010;
    localparam logic [CFG_W-1:0] CFG_TAP1 = 3'b100;

    // mode values
    localparam logic [15:0] D2_MODE_DLLRST = 16'h0100;
    localparam logic [15:0] D2_MODE_RUN    = 16'h0A33;
    localparam logic [15:0] D2_EMR_CAL_IN  = 16'h0382;
    localparam logic [15:0] D2_EMR_CAL_OUT = 16'h0402;
    localparam logic [15:0] D1_MODE_DLLRST = 16'h0133;
    localparam logic [15:0] D1_EMR_RUN     = 16'h0002;
    localparam logic [15:0] D1_MODE_RUN    = 16'h0033;

    localparam int RFSH_EN_BIT = 14;
    localparam int RFSH_CNT_MASK = 32'h3FF;

    localparam int D2_STEPS = 14;
    localparam int D1_STEPS = 8;
    localparam int IDX_W = $clog2(D2_STEPS);

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DONE   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ddr_seq_straps.sv
module ddr_seq_straps (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic ddr2_in,
    input  logic ref40_in,
    output logic ddr2_q,
    output logic ref40_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ddr2_q  <= 1'b0;
            ref40_q <= 1'b0;
        end else if (capture) begin
            ddr2_q  <= ddr2_in;
            ref40_q <= ref40_in;
        end
    end

endmodule

// File: rtl/ddr_seq_script.sv
module ddr_seq_script
    import ddr_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int REF_CNT_40M = 624,
    parameter int REF_CNT_25M = 390,
    parameter int TAP_LANE0   = 8,
    parameter int TAP_LANE1   = 9
) (
    input  logic              ddr2,
    input  logic              ref40,
    input  logic [IDX_W-1:0]  idx,
    output logic [CMD_W-1:0]  cmd,
    output logic [CFG_W-1:0]  cfg,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    localparam logic [DATA_W-1:0] RFSH_40 =
        DATA_W'((32'd1 << RFSH_EN_BIT) | (REF_CNT_40M & RFSH_CNT_MASK));
    localparam logic [DATA_W-1:0] RFSH_25 =
        DATA_W'((32'd1 << RFSH_EN_BIT) | (REF_CNT_25M & RFSH_CNT_MASK));
    localparam logic [DATA_W-1:0] TAP0_W = DATA_W'(TAP_LANE0);
    localparam logic [DATA_W-1:0] TAP1_W = DATA_W'(TAP_LANE1);

    logic [DATA_W-1:0] rfsh_word;
    logic [IDX_W-1:0]  cfg_base;
    logic [IDX_W-1:0]  rel;

    assign rfsh_word = ref40 ? RFSH_40 : RFSH_25;
    assign cfg_base  = ddr2 ? IDX_W'(D2_STEPS - 3) : IDX_W'(D1_STEPS - 3);
    assign rel       = idx - cfg_base;

    always_comb begin
        cmd  = CMD_NONE;
        cfg  = CFG_NONE;
        data = '0;
        last = 1'b0;
        if (idx >= cfg_base) begin
            // shared tail: refresh word, then lane taps
            unique case (rel)
                IDX_W'(0): begin cfg = CFG_RFSH; data = rfsh_word; end
                IDX_W'(1): begin cfg = CFG_TAP0; data = TAP0_W;    end
                IDX_W'(2): begin cfg = CFG_TAP1; data = TAP1_W; last = 1'b1; end
                default:   begin cfg = CFG_NONE; end
            endcase
        end else if (ddr2) begin
            unique case (idx)
                IDX_W'(0):  cmd = CMD_PALL;
                IDX_W'(1):  cmd = CMD_EMR2;
                IDX_W'(2):  cmd = CMD_EMR3;
                IDX_W'(3):  cmd = CMD_EMR;
                IDX_W'(4):  begin cmd = CMD_MRS; data = DATA_W'(D2_MODE_DLLRST); end
                IDX_W'(5):  cmd = CMD_PALL;
                IDX_W'(6):  cmd = CMD_AREF;
                IDX_W'(7):  cmd = CMD_AREF;
                IDX_W'(8):  begin cmd = CMD_MRS; data = DATA_W'(D2_MODE_RUN); end
                IDX_W'(9):  begin cmd = CMD_EMR; data = DATA_W'(D2_EMR_CAL_IN); end
                IDX_W'(10): begin cmd = CMD_EMR; data = DATA_W'(D2_EMR_CAL_OUT); end
                default:    cmd = CMD_NONE;
            endcase
        end else begin
            unique case (idx)
                IDX_W'(0): cmd = CMD_PALL;
                IDX_W'(1): begin cmd = CMD_MRS; data = DATA_W'(D1_MODE_DLLRST); end
                IDX_W'(2): begin cmd = CMD_EMR; data = DATA_W'(D1_EMR_RUN); end
                IDX_W'(3): cmd = CMD_PALL;
                IDX_W'(4): begin cmd = CMD_MRS; data = DATA_W'(D1_MODE_RUN); end
                default:   cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ddr_seq_fsm.sv
module ddr_seq_fsm
    import ddr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  logic             last,
    output logic [IDX_W-1:0] idx,
    output logic             capture,
    output logic             issuing,
    output logic             done
);

    seq_state_e       state, state_nxt;
    logic [IDX_W-1:0] idx_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SAMPLE;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        unique case (state)
            ST_SAMPLE: begin
                state_nxt = ST_ISSUE;
                idx_nxt   = '0;
            end
            ST_ISSUE: begin
                if (ack) begin
                    if (last) state_nxt = ST_DONE;
                    else      idx_nxt   = idx + IDX_W'(1);
                end
            end
            ST_DONE: begin
                state_nxt = ST_DONE;
            end
            default: begin
                state_nxt = ST_SAMPLE;
                idx_nxt   = '0;
            end
        endcase
    end

    always_comb begin
        capture = (state == ST_SAMPLE);
        issuing = (state == ST_ISSUE);
        done    = (state == ST_DONE);
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int REF_CNT_40M = 624,
    parameter int REF_CNT_25M = 390,
    parameter int TAP_LANE0   = 8,
    parameter int TAP_LANE1   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ddr2,
    input  logic              strap_ref40,
    input  logic              ctl_ack,
    output logic [5:0]        mem_cmd,
    output logic [2:0]        cfg_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              seq_done
);

    logic              capture;
    logic              issuing;
    logic              running;
    logic              ddr2_q;
    logic              ref40_q;
    logic [IDX_W-1:0]  idx;
    logic [CMD_W-1:0]  s_cmd;
    logic [CFG_W-1:0]  s_cfg;
    logic [DATA_W-1:0] s_data;
    logic              s_last;

    ddr_seq_straps u_straps (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .ddr2_in  (strap_ddr2),
        .ref40_in (strap_ref40),
        .ddr2_q   (ddr2_q),
        .ref40_q  (ref40_q)
    );

    ddr_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ctl_ack),
        .last    (s_last),
        .idx     (idx),
        .capture (capture),
        .issuing (issuing),
        .done    (seq_done)
    );

    ddr_seq_script #(
        .DATA_W      (DATA_W),
        .REF_CNT_40M (REF_CNT_40M),
        .REF_CNT_25M (REF_CNT_25M),
        .TAP_LANE0   (TAP_LANE0),
        .TAP_LANE1   (TAP_LANE1)
    ) u_script (
        .ddr2  (ddr2_q),
        .ref40 (ref40_q),
        .idx   (idx),
        .cmd   (s_cmd),
        .cfg   (s_cfg),
        .data  (s_data),
        .last  (s_last)
    );

    assign running = !capture;
    assign mem_cmd = issuing ? s_cmd  : '0;
    assign cfg_sel = issuing ? s_cfg  : '0;
    assign wr_data = issuing ? s_data : '0;

endmodule

// File: rtl/ddr_seq_checker.sv
module ddr_seq_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [5:0]        cmd,
    input logic [2:0]        cfg,
    input logic [DATA_W-1:0] data,
    input logic              done,
    input logic              running,
    input logic              ddr2_q,
    input logic              ref40_q
);

    logic req;
    assign req = (cmd != 6'd0) || (cfg != 3'd0);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd, cfg}));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(cmd) && $stable(cfg) && $stable(data)));

    assert_refword_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == 3'b001) |-> (data[14] && (data[13:10] == 4'd0) && ((data >> 15) == '0)));

    assert_strap_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> ($stable(ddr2_q) && $stable(ref40_q)));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);

    assert_idle_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!req && !done));

endmodule

bind ddr_init_seq ddr_seq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ctl_ack),
    .cmd     (mem_cmd),
    .cfg     (cfg_sel),
    .data    (wr_data),
    .done    (seq_done),
    .running (running),
    .ddr2_q  (ddr2_q),
    .ref40_q (ref40_q)
);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_ddr2 = 1'b0;
    logic        strap_ref40 = 1'b0;
    logic        ctl_ack = 1'b0;
    logic [5:0]  mem_cmd;
    logic [2:0]  cfg_sel;
    logic [15:0] wr_data;
    logic        seq_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;  // 125 MHz

    ddr_init_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_ddr2  (strap_ddr2),
        .strap_ref40 (strap_ref40),
        .ctl_ack     (ctl_ack),
        .mem_cmd     (mem_cmd),
        .cfg_sel     (cfg_sel),
        .wr_data     (wr_data),
        .seq_done    (seq_done)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected {cmd[5:0], cfg[2:0], data[15:0]} from the requirement tables
    function automatic logic [24:0] exp_step(bit d2, bit r40, int i);
        logic [15:0] rw;
        int          tail;
        rw   = 16'h4000 | (r40 ? 16'd624 : 16'd390);
        tail = d2 ? 11 : 5;
        if (i == tail)     return {6'b000000, 3'b001, rw};
        if (i == tail + 1) return {6'b000000, 3'b010, 16'h0008};
        if (i == tail + 2) return {6'b000000, 3'b100, 16'h0009};
        if (d2) begin
            case (i)
                0:  return {6'b001000, 3'b000, 16'h0000};
                1:  return {6'b010000, 3'b000, 16'h0000};
                2:  return {6'b100000, 3'b000, 16'h0000};
                3:  return {6'b000010, 3'b000, 16'h0000};
                4:  return {6'b000001, 3'b000, 16'h0100};
                5:  return {6'b001000, 3'b000, 16'h0000};
                6:  return {6'b000100, 3'b000, 16'h0000};
                7:  return {6'b000100, 3'b000, 16'h0000};
                8:  return {6'b000001, 3'b000, 16'h0A33};
                9:  return {6'b000010, 3'b000, 16'h0382};
                default: return {6'b000010, 3'b000, 16'h0402};
            endcase
        end
        case (i)
            0: return {6'b001000, 3'b000, 16'h0000};
            1: return {6'b000001, 3'b000, 16'h0133};
            2: return {6'b000010, 3'b000, 16'h0002};
            3: return {6'b001000, 3'b000, 16'h0000};
            default: return {6'b000001, 3'b000, 16'h0033};
        endcase
    endfunction

    task automatic run_case(bit d2, bit r40, int lat, bit flip);
        int n;
        n = d2 ? 14 : 8;
        @(negedge clk);
        rst_n       = 1'b0;
        strap_ddr2  = d2;
        strap_ref40 = r40;
        ctl_ack     = 1'b0;
        repeat (2) @(negedge clk);
        check(mem_cmd == 0 && cfg_sel == 0 && !seq_done, "R1 in reset",
              {23'd0, mem_cmd, cfg_sel}, 32'd0);
        rst_n = 1'b1;
        #1;
        check(mem_cmd == 0 && cfg_sel == 0 && !seq_done, "R1 after release",
              {23'd0, mem_cmd, cfg_sel}, 32'd0);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [24:0] e;
            logic [24:0] a;
            string       tag;
            e = exp_step(d2, r40, i);
            a = {mem_cmd, cfg_sel, wr_data};
            if (e[18:16] == 3'b001)      tag = "R6 refresh word";
            else if (e[18:16] != 3'b000) tag = "R7 tap write";
            else if (d2)                 tag = "R4 ddr2 step";
            else                         tag = "R5 ddr1 step";
            if (flip) tag = {tag, " R8 straps flipped"};
            check(a == e, tag, {7'd0, a}, {7'd0, e});
            if (flip && i == 0) begin
                strap_ddr2  = !d2;
                strap_ref40 = !r40;
            end
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                check({mem_cmd, cfg_sel, wr_data} == e, "R3 R10 hold without ack",
                      {7'd0, mem_cmd, cfg_sel, wr_data}, {7'd0, e});
            end
            ctl_ack = 1'b1;
            @(negedge clk);
            ctl_ack = 1'b0;
            if (i < n - 1)
                check(!seq_done, "R9 done early", {31'd0, seq_done}, 32'd0);
        end
        check(seq_done && mem_cmd == 0 && cfg_sel == 0, "R9 done after last ack",
              {22'd0, seq_done, mem_cmd, cfg_sel}, {22'd0, 1'b1, 9'd0});
        ctl_ack = 1'b1;
        repeat (2) @(negedge clk);
        ctl_ack = 1'b0;
        @(negedge clk);
        check(seq_done && mem_cmd == 0 && cfg_sel == 0 && wr_data == 0,
              "R9 ack ignored after done",
              {6'd0, seq_done, mem_cmd, cfg_sel, wr_data}, {6'd0, 1'b1, 25'd0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int d = 0; d < 2; d++)
            for (int r = 0; r < 2; r++)
                for (int l = 0; l < 3; l++) begin
                    int lat;
                    lat = (l == 0) ? 0 : ((l == 1) ? 1 : 3);
                    run_case(d[0], r[0], lat, l == 1);
                end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule